// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Scheduler

This block owns every refresh of an asynchronous DRAM that refreshes its rows from an internal counter when the column strobe falls before the row strobe. After reset it stays silent for a start-up pause. It then runs a fixed burst of start-up refreshes and raises a ready flag. From then on an interval counter adds one owed refresh per slot. The slot length is chosen so that every row is refreshed within the retention period. Each slot's refresh is issued as soon as the access controller lets go of the bus.

The access controller sees a request line and answers with a grant. The block takes the bus on the clock edge where it samples request and grant both high. It holds a bus-ownership flag for the whole strobe sequence and drives both strobes itself. While it owns the bus the address and data pins are not used. The controller must keep its output enable inactive, so that the data pins stay high-impedance. Slots that pass while the controller holds the bus are counted, up to a small limit, and the owed refreshes are then issued back to back. Every timing value is a parameter counted in clock cycles.

Top module: `dram_rfsh_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both strobes are high (inactive) and the request, ownership and ready outputs are low.
- R2: The request stays low until PAUSE_CYC rising clock edges have passed after reset release. It then rises, and the block issues exactly INIT_REFRESHES refresh sequences before ready.
- R3: In each sequence the column strobe goes low LEAD_CYC cycles before the row strobe falls. It stays low for HOLD_CYC cycles after the row strobe falls.
- R4: The row strobe stays low for RAS_LOW_CYC cycles. Both strobes are then high for PRE_CYC cycles of precharge before the bus is released.
- R5: The ready output rises on the clock edge that ends the precharge of the last start-up refresh, and it stays high until reset.
- R6: Once ready, one refresh is owed every INTERVAL_CYC cycles. The first is owed INTERVAL_CYC cycles after ready rises. The schedule does not depend on grants. The request is high exactly when a refresh is owed and no sequence is running.
- R7: A sequence starts on the edge that samples request and grant both high. The request then drops, and ownership is high for exactly LEAD_CYC+RAS_LOW_CYC+PRE_CYC cycles. A grant that arrives while no request is raised starts nothing.
- R8: At most MAX_PEND refreshes are owed at once, and further slots are dropped. Owed refreshes are served back to back, with one idle cycle between sequences when the grant is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rfsh_gnt_i | input | 1 | Bus grant from the access controller |
| rfsh_req_o | output | 1 | Refresh wants the bus |
| bus_own_o | output | 1 | Scheduler owns the strobes this cycle |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| init_ready_o | output | 1 | Start-up refreshes complete |

## Verification
The request reacts with no delay to the registered state. It rises right after the PAUSE_CYC-th edge, and INTERVAL_CYC edges after each slot begins. Strobes and ownership change one edge after the grant is sampled. They then follow a fixed cycle-by-cycle pattern over LEAD_CYC+RAS_LOW_CYC+PRE_CYC cycles. Ready changes on the edge that ends the last start-up precharge. The bench keeps a reference model that it advances on every rising edge using only its own grant. It compares all outputs with the model on every falling edge, so each result is checked in the exact cycle it is due.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

   // strobe sequencer phases, in the order they are visited
   typedef enum logic [2:0] {
      SQ_IDLE  = 3'd0,
      SQ_LEAD  = 3'd1,   // column strobe low, row strobe high
      SQ_HOLD  = 3'd2,   // both strobes low
      SQ_RASLO = 3'd3,   // row strobe low, column strobe released
      SQ_PRECH = 3'd4    // both high, bus still owned
   } seq_state_e;

   function automatic int unsigned max4(int unsigned a, int unsigned b,
                                        int unsigned c, int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/dram_rfsh_timer.sv
module dram_rfsh_timer #(
   parameter int unsigned PAUSE_CYC    = 25000,
   parameter int unsigned INTERVAL_CYC = 1950
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic pause_done_o,
   output logic tick_o
);
   localparam int unsigned PW = $clog2(PAUSE_CYC);
   localparam int unsigned IW = $clog2(INTERVAL_CYC);
   localparam logic [PW-1:0] PAUSE_LAST = PW'(PAUSE_CYC - 1);
   localparam logic [IW-1:0] INT_LAST   = IW'(INTERVAL_CYC - 1);

   logic [PW-1:0] pause_cnt;
   logic [IW-1:0] slot_cnt;
   logic          pause_done_q;

   // start-up pause: counts edges once, then stays done
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pause_cnt    <= '0;
         pause_done_q <= 1'b0;
      end else if (!pause_done_q) begin
         if (pause_cnt == PAUSE_LAST) pause_done_q <= 1'b1;
         else                         pause_cnt    <= pause_cnt + 1'b1;
      end
   end

   // slot counter: free-running once enabled, independent of bus grants
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  slot_cnt <= '0;
      else if (run_i) begin
         if (slot_cnt == INT_LAST) slot_cnt <= '0;
         else                      slot_cnt <= slot_cnt + 1'b1;
      end
   end

   assign pause_done_o = pause_done_q;
   assign tick_o       = run_i && (slot_cnt == INT_LAST);

   AST_TICK_AFTER_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |-> pause_done_q);  // R6

endmodule

// File: rtl/dram_rfsh_pending.sv
module dram_rfsh_pending #(
   parameter int unsigned MAX_PEND = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic take_i,
   output logic pend_any_o,
   output logic pend_full_o
);
   generate
      if (MAX_PEND == 1) begin : g_flag
         logic owed_q;
         logic owed_left;
         always_comb owed_left = owed_q & ~take_i;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) owed_q <= 1'b0;
            else        owed_q <= owed_left | tick_i;
         end
         assign pend_any_o  = owed_q;
         assign pend_full_o = owed_q;
      end else begin : g_count
         localparam int unsigned CW = $clog2(MAX_PEND + 1);
         localparam logic [CW-1:0] FULL = CW'(MAX_PEND);
         logic [CW-1:0] owed_q;
         logic [CW-1:0] owed_left;
         logic [CW-1:0] owed_nxt;
         always_comb begin
            owed_left = owed_q - CW'(take_i);
            owed_nxt  = owed_left;
            if (tick_i && (owed_left < FULL)) owed_nxt = owed_left + 1'b1;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) owed_q <= '0;
            else        owed_q <= owed_nxt;
         end
         assign pend_any_o  = (owed_q != '0);
         assign pend_full_o = (owed_q == FULL);
      end
   endgenerate

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_full_o && tick_i && !take_i) |=> pend_full_o);  // R8
   AST_TAKE_NEEDS_OWED: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |-> pend_any_o);  // R6

endmodule

// File: rtl/dram_rfsh_seq.sv
module dram_rfsh_seq
   import dram_rfsh_pkg::*;
#(
   parameter int unsigned LEAD_CYC    = 2,
   parameter int unsigned HOLD_CYC    = 3,
   parameter int unsigned RAS_LOW_CYC = 10,
   parameter int unsigned PRE_CYC     = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic ras_n_o,
   output logic cas_n_o,
   output logic busy_o,
   output logic done_o
);
   localparam int unsigned TAIL_CYC = RAS_LOW_CYC - HOLD_CYC;
   localparam int unsigned MAXD     = max4(LEAD_CYC, HOLD_CYC, TAIL_CYC, PRE_CYC);
   localparam int unsigned CW       = $clog2(MAXD + 1);
   localparam logic [CW-1:0] LD_LEAD = CW'(LEAD_CYC - 1);
   localparam logic [CW-1:0] LD_HOLD = CW'(HOLD_CYC - 1);
   localparam logic [CW-1:0] LD_TAIL = CW'(TAIL_CYC - 1);
   localparam logic [CW-1:0] LD_PRE  = CW'(PRE_CYC - 1);

   seq_state_e    st_q, st_nxt;
   logic [CW-1:0] cnt_q, cnt_nxt;
   logic          ras_n_q, cas_n_q;
   logic          last;

   assign last = (cnt_q == '0);

   always_comb begin
      st_nxt  = st_q;
      cnt_nxt = last ? cnt_q : cnt_q - 1'b1;
      unique case (st_q)
         SQ_IDLE:  if (start_i) begin st_nxt = SQ_LEAD;  cnt_nxt = LD_LEAD; end
         SQ_LEAD:  if (last)    begin st_nxt = SQ_HOLD;  cnt_nxt = LD_HOLD; end
         SQ_HOLD:  if (last)    begin st_nxt = SQ_RASLO; cnt_nxt = LD_TAIL; end
         SQ_RASLO: if (last)    begin st_nxt = SQ_PRECH; cnt_nxt = LD_PRE;  end
         SQ_PRECH: if (last)    begin st_nxt = SQ_IDLE;  cnt_nxt = '0;      end
         default:               begin st_nxt = SQ_IDLE;  cnt_nxt = '0;      end
      endcase
   end

   // strobes are registered from the next phase so they are glitch-free
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= SQ_IDLE;
         cnt_q   <= '0;
         ras_n_q <= 1'b1;
         cas_n_q <= 1'b1;
      end else begin
         st_q    <= st_nxt;
         cnt_q   <= cnt_nxt;
         ras_n_q <= !((st_nxt == SQ_HOLD) || (st_nxt == SQ_RASLO));
         cas_n_q <= !((st_nxt == SQ_LEAD) || (st_nxt == SQ_HOLD));
      end
   end

   assign ras_n_o = ras_n_q;
   assign cas_n_o = cas_n_q;
   assign busy_o  = (st_q != SQ_IDLE);
   assign done_o  = (st_q == SQ_PRECH) && last;

   AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n_q) |-> (!cas_n_q && $past(!cas_n_q)));  // R3
   AST_PRECH_BOTH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n_q) |-> cas_n_q);  // R4
   AST_STROBE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (!ras_n_q || !cas_n_q) |-> busy_o);  // R7
   AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !busy_o);  // R7

endmodule

// File: rtl/dram_rfsh_sched.sv
module dram_rfsh_sched #(
   parameter int unsigned PAUSE_CYC      = 25000,
   parameter int unsigned INIT_REFRESHES = 8,
   parameter int unsigned INTERVAL_CYC   = 1950,
   parameter int unsigned LEAD_CYC       = 2,
   parameter int unsigned HOLD_CYC       = 3,
   parameter int unsigned RAS_LOW_CYC    = 10,
   parameter int unsigned PRE_CYC        = 8,
   parameter int unsigned MAX_PEND       = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rfsh_gnt_i,
   output logic rfsh_req_o,
   output logic bus_own_o,
   output logic ras_n_o,
   output logic cas_n_o,
   output logic init_ready_o
);
   localparam int unsigned SEQ_CYC = LEAD_CYC + RAS_LOW_CYC + PRE_CYC;
   localparam int unsigned NW      = $clog2(INIT_REFRESHES + 1);

   generate
      if (LEAD_CYC < 1 || HOLD_CYC < 1 || PRE_CYC < 1) begin : g_bad_phase
         $error("dram_rfsh_sched: every strobe phase needs at least one cycle");
      end
      if (RAS_LOW_CYC <= HOLD_CYC) begin : g_bad_raslow
         $error("dram_rfsh_sched: RAS_LOW_CYC must exceed HOLD_CYC");
      end
      if (INIT_REFRESHES < 1 || MAX_PEND < 1 || PAUSE_CYC < 2) begin : g_bad_count
         $error("dram_rfsh_sched: counts out of range");
      end
      if (INTERVAL_CYC <= SEQ_CYC + 1) begin : g_bad_slot
         $error("dram_rfsh_sched: INTERVAL_CYC must exceed one sequence");
      end
   endgenerate

   logic          pause_done, tick;
   logic          owed_any, owed_full;
   logic          busy, done, start;
   logic          ready_q;
   logic [NW-1:0] init_left_q;

   dram_rfsh_timer #(
      .PAUSE_CYC    (PAUSE_CYC),
      .INTERVAL_CYC (INTERVAL_CYC)
   ) u_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .run_i        (ready_q),
      .pause_done_o (pause_done),
      .tick_o       (tick)
   );

   dram_rfsh_pending #(
      .MAX_PEND    (MAX_PEND)
   ) u_pending (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (tick),
      .take_i      (start && ready_q),
      .pend_any_o  (owed_any),
      .pend_full_o (owed_full)
   );

   dram_rfsh_seq #(
      .LEAD_CYC    (LEAD_CYC),
      .HOLD_CYC    (HOLD_CYC),
      .RAS_LOW_CYC (RAS_LOW_CYC),
      .PRE_CYC     (PRE_CYC)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .ras_n_o (ras_n_o),
      .cas_n_o (cas_n_o),
      .busy_o  (busy),
      .done_o  (done)
   );

   // start-up burst bookkeeping
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_left_q <= NW'(INIT_REFRESHES);
         ready_q     <= 1'b0;
      end else if (done && !ready_q) begin
         init_left_q <= init_left_q - 1'b1;
         if (init_left_q == NW'(1)) ready_q <= 1'b1;
      end
   end

   assign rfsh_req_o   = !busy && (ready_q ? owed_any
                                           : (pause_done && (init_left_q != '0)));
   assign start        = rfsh_req_o && rfsh_gnt_i;
   assign bus_own_o    = busy;
   assign init_ready_o = ready_q;

   AST_NO_REQ_IN_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      !pause_done |-> !rfsh_req_o);  // R2
   AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ready_q |=> ready_q);  // R5
   AST_GRANT_TAKES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      (rfsh_req_o && rfsh_gnt_i) |=> (bus_own_o && !rfsh_req_o));  // R7
   AST_FULL_IMPLIES_REQ_OR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      owed_full |-> (rfsh_req_o || busy));  // R8

endmodule

// File: tb/dram_rfsh_sched_tb.sv
module dram_rfsh_sched_tb;
   localparam int PAUSE = 300;
   localparam int NINIT = 8;
   localparam int SLOT  = 150;
   localparam int LEAD  = 2;
   localparam int HOLD  = 3;
   localparam int RLOW  = 10;
   localparam int PRE   = 8;
   localparam int MAXP  = 3;
   localparam int SEQ   = LEAD + RLOW + PRE;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic gnt = 1'b0;
   logic req, own, ras_n, cas_n, rdy;

   always #4 clk = ~clk;

   dram_rfsh_sched #(
      .PAUSE_CYC(PAUSE), .INIT_REFRESHES(NINIT), .INTERVAL_CYC(SLOT),
      .LEAD_CYC(LEAD), .HOLD_CYC(HOLD), .RAS_LOW_CYC(RLOW), .PRE_CYC(PRE),
      .MAX_PEND(MAXP)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .rfsh_gnt_i(gnt), .rfsh_req_o(req),
      .bus_own_o(own), .ras_n_o(ras_n), .cas_n_o(cas_n), .init_ready_o(rdy)
   );

   int n_cmp = 0;
   int n_bad = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s at t=%0t: actual=%0d expected=%0d", tag, $time, act, exp);
      end
   endtask

   // reference model, advanced on each rising edge from the bench's own grant
   int cyc = 0;
   bit m_pause_done = 0;
   int m_init_left = NINIT;
   bit m_ready = 0;
   int m_ready_cyc = 0;
   int m_pend = 0;
   int m_k = 0;
   bit m_req = 0;

   function automatic bit exp_cas_low(int k);
      return (k >= 1) && (k <= LEAD + HOLD);
   endfunction
   function automatic bit exp_ras_low(int k);
      return (k > LEAD) && (k <= LEAD + RLOW);
   endfunction

   always @(posedge clk) begin
      if (rst_n) begin : model_step
         bit acc, done, tick;
         acc  = m_req && gnt;
         done = 1'b0;
         cyc++;
         tick = m_ready && (cyc > m_ready_cyc) && (((cyc - m_ready_cyc) % SLOT) == 0);
         if (!m_pause_done && cyc == PAUSE) m_pause_done = 1'b1;
         if (m_k != 0) begin
            if (m_k == SEQ) begin m_k = 0; done = 1'b1; end
            else m_k++;
         end else if (acc) m_k = 1;
         if (acc && m_ready) m_pend--;
         if (tick && m_pend < MAXP) m_pend++;
         if (done && !m_ready) begin
            m_init_left--;
            if (m_init_left == 0) begin m_ready = 1'b1; m_ready_cyc = cyc; end
         end
         m_req = (m_k == 0) && (m_ready ? (m_pend != 0)
                                        : (m_pause_done && m_init_left != 0));
      end
   end

   // compare every output with the model away from the rising edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (!m_ready)            chk(req == m_req, "R2 request", req, m_req);
         else if (m_pend == MAXP) chk(req == m_req, "R8 request", req, m_req);
         else                     chk(req == m_req, "R6 request", req, m_req);
         chk(own == (m_k != 0), "R7 ownership", own, m_k != 0);
         chk(cas_n == !exp_cas_low(m_k), "R3 column strobe", cas_n, !exp_cas_low(m_k));
         chk(ras_n == !exp_ras_low(m_k), "R4 row strobe", ras_n, !exp_ras_low(m_k));
         chk(rdy == m_ready, "R5 ready", rdy, m_ready);
      end
   end

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #(100000 * 8);
      n_cmp++;
      n_bad++;
      $display("FAIL R7 watchdog: actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      // R1: reset state, held and checked before release
      repeat (3) @(negedge clk);
      chk(req == 1'b0,   "R1 request in reset", req, 0);
      chk(own == 1'b0,   "R1 ownership in reset", own, 0);
      chk(ras_n == 1'b1, "R1 row strobe in reset", ras_n, 1);
      chk(cas_n == 1'b1, "R1 column strobe in reset", cas_n, 1);
      chk(rdy == 1'b0,   "R1 ready in reset", rdy, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req == 1'b0 && own == 1'b0 && ras_n && cas_n, "R1 first cycle", req, 0);

      // random grants, including grants during the pause (R7 ignored grant)
      for (int i = 0; i < 1500; i++) begin
         gnt = (($urandom % 3) == 0);
         @(negedge clk);
      end
      // directed: hold the bus long enough to saturate the owed count (R8)
      gnt = 1'b0;
      repeat (5 * SLOT + 7) @(negedge clk);
      chk(req == 1'b1, "R8 request after stall", req, 1);
      // release the bus: owed refreshes run back to back
      gnt = 1'b1;
      repeat (120) @(negedge clk);
      // sparse random grants in steady operation
      for (int i = 0; i < 2500; i++) begin
         gnt = (($urandom % 5) == 0);
         @(negedge clk);
      end
      gnt = 1'b0;
      chk(rdy == 1'b1, "R5 ready at end", rdy, 1);
      summary();
      $finish;
   end

endmodule